// File: doc/BRIEF.md
# Passive LCD Frame Scan Controller

This block streams a frame buffer held in memory out to a passive LCD panel. The panel data bus is 4 bits wide. Alongside the data, the block drives a line strobe, a frame strobe and an AC-bias toggle. The frame geometry comes from four settings: pixel width, pixel height, pixel depth mode and dual-panel split. From these the block derives how many nibbles make up one line and how many lines make up one frame.

Memory is read one word at a time through a request/grant port. The address runs linearly from a start address up to an exclusive end address. If a nibble is due and no word is ready, the block outputs a blank nibble and records the miss in a sticky underrun flag.

Software controls the scan with two inputs. An enable turns scanning on and off. A freeze control halts scanning cleanly at the end of the frame in progress. Restarting after a halt needs an enable low/high cycle, and the scan then begins again at the start address.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: After reset, and on the first clock after `cfg_en` goes low, `lcd_data` is 0 and `lcd_line`, `lcd_frame`, `lcd_df` and `mem_req` are 0. Disabling also resets the line counter, the nibble counter and the read address, so that the next enable starts a fresh frame.
- R2: Each line carries `npl` nibbles, one per clock. `npl` = (width/8)*3 when mode is 3 and split is off; otherwise `npl` = width/4. The nibbles are followed by exactly one cycle with `lcd_line` = 1 and `lcd_data` = 0.
- R3: A frame has `height` lines, or `height/2` lines when split is on. `lcd_frame` is 1 for every cycle of the first line, including that line's strobe cycle, and 0 on all other lines.
- R4: Data is packed linearly across lines. Memory words are 16 bits, read from `cfg_start` upward. Within a word, nibble [3:0] goes out first, then [7:4], then [11:8], then [15:12]. `mem_rdata` is taken in the cycle in which `mem_req` and `mem_grant` are both 1.
- R5: With `cfg_invert` = 1, every nibble read from memory is complemented on `lcd_data`.
- R6: With `cfg_df_line` = 0, `lcd_df` keeps one value for a whole frame and flips between consecutive frames. With `cfg_df_line` = 1, it flips after every line strobe, so consecutive lines alternate.
- R7: No read is requested at or above `cfg_end`. A nibble slot with no word available outputs 0 and sets `underrun`. `underrun` stays set until `cfg_en` is low.
- R8: When `cfg_freeze` is 1, the frame in progress completes and scanning then stops. All strobes and data stay at 0 and no reads are made. Clearing the freeze alone does not resume scanning. Scanning resumes only after `cfg_en` is taken low and then high again.
- R9: Every frame, including the first frame after a restart, begins at `cfg_start`, so repeated frames carry identical data.
- R10: The depth select encodes 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp. Only mode 3 without split uses the colour line length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one nibble per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Scan enable |
| cfg_freeze | input | 1 | Stop at the end of the current frame |
| cfg_bpp | input | 2 | Pixel depth mode select |
| cfg_split | input | 1 | Dual-panel split |
| cfg_width | input | WW (10) | Panel width in pixels |
| cfg_height | input | HW (9) | Panel height in lines |
| cfg_start | input | AW (16) | First word address of the frame buffer |
| cfg_end | input | AW (16) | Word address one past the frame buffer |
| cfg_invert | input | 1 | Complement the output data |
| cfg_df_line | input | 1 | 0: bias toggles per frame, 1: per line |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW (16) | Read word address |
| mem_grant | input | 1 | Read accepted, data valid this cycle |
| mem_rdata | input | DW (16) | Read data |
| lcd_data | output | 4 | Panel data nibble |
| lcd_line | output | 1 | Line strobe |
| lcd_frame | output | 1 | Frame strobe |
| lcd_df | output | 1 | AC-bias toggle |
| underrun | output | 1 | Sticky missing-data flag |

## Verification
The hardest state to reach from the ports is the halt that follows a freeze. The freeze has to be raised while a frame is already running. The bench raises it on the first nibble of a frame and then checks three things in turn: that the rest of that frame comes out intact, that the block stays silent with the freeze still set, and that it stays silent after the freeze is cleared with the enable still high. Only after that does it cycle the enable and look for a frame that starts at the start address. Underrun is forced deterministically by setting the end address one word past the start. The exact nibble at which blank output begins is therefore known in advance.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    DEPTH_1  = 2'd0,
    DEPTH_2  = 2'd1,
    DEPTH_4  = 2'd2,
    DEPTH_8  = 2'd3
  } depth_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_SCAN  = 2'd2,
    ST_HALT  = 2'd3
  } scan_st_e;

endpackage

// File: rtl/lcd_geom.sv
module lcd_geom
  import lcd_scan_pkg::*;
#(
  parameter int WW = 10,
  parameter int HW = 9
) (
  input  logic [1:0]    bpp,
  input  logic          split,
  input  logic [WW-1:0] width,
  input  logic [HW-1:0] height,
  output logic [WW-1:0] npl,
  output logic [HW-1:0] lpf
);

  always_comb begin
    if (depth_e'(bpp) == DEPTH_8 && !split) npl = WW'((width >> 3) * 3);
    else                                    npl = width >> 2;
    lpf = split ? (height >> 1) : height;
  end

endmodule

// File: rtl/lcd_fetch.sv
module lcd_fetch #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          take,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_grant,
  input  logic [DW-1:0] mem_rdata,
  output logic          avail,
  output logic [3:0]    nib
);

  localparam int NPW = DW / 4;
  localparam int SW  = (NPW > 1) ? $clog2(NPW) : 1;

  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] cur_q, cur_d, nxt_q, nxt_d;
  logic          cur_v_q, cur_v_d, nxt_v_q, nxt_v_d;
  logic [SW-1:0] sel_q, sel_d;
  logic          fire, last, load_cur;

  assign mem_req  = !flush && !nxt_v_q && (addr_q != end_addr);
  assign mem_addr = addr_q;
  assign avail    = cur_v_q;
  assign nib      = cur_q[int'(sel_q)*4 +: 4];

  always_comb begin
    fire     = mem_req && mem_grant;
    last     = take && cur_v_q && (sel_q == SW'(NPW-1));
    load_cur = (!cur_v_q || last) && nxt_v_q;
    addr_d   = addr_q;
    cur_d    = cur_q;
    nxt_d    = nxt_q;
    cur_v_d  = cur_v_q;
    nxt_v_d  = nxt_v_q;
    sel_d    = sel_q;
    if (flush) begin
      addr_d  = start_addr;
      cur_v_d = 1'b0;
      nxt_v_d = 1'b0;
      sel_d   = '0;
    end else begin
      if (take && cur_v_q) sel_d = (sel_q == SW'(NPW-1)) ? '0 : sel_q + 1'b1;
      if (load_cur) begin
        cur_d   = nxt_q;
        cur_v_d = 1'b1;
        nxt_v_d = 1'b0;
      end else if (last) begin
        cur_v_d = 1'b0;
      end
      if (fire) begin
        nxt_d   = mem_rdata;
        nxt_v_d = 1'b1;
        addr_d  = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cur_q   <= '0;
      nxt_q   <= '0;
      cur_v_q <= 1'b0;
      nxt_v_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      addr_q  <= addr_d;
      cur_q   <= cur_d;
      nxt_q   <= nxt_d;
      cur_v_q <= cur_v_d;
      nxt_v_q <= nxt_v_d;
      sel_q   <= sel_d;
    end
  end

  AST_FLUSH_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (mem_addr == $past(start_addr))); // R9
  AST_GRANT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_grant) |=> (nxt_v_q || avail)); // R4

endmodule

// File: rtl/lcd_timing.sv
module lcd_timing
  import lcd_scan_pkg::*;
#(
  parameter int WW = 10,
  parameter int HW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_freeze,
  input  logic          cfg_invert,
  input  logic          cfg_df_line,
  input  logic [WW-1:0] geo_npl,
  input  logic [HW-1:0] geo_lpf,
  input  logic          avail,
  input  logic [3:0]    nib,
  output logic          take,
  output logic          flush,
  output logic [3:0]    lcd_data,
  output logic          lcd_line,
  output logic          lcd_frame,
  output logic          lcd_df,
  output logic          underrun
);

  scan_st_e      state_q, state_d;
  logic [WW-1:0] hcnt_q, hcnt_d, npl_q;
  logic [HW-1:0] vcnt_q, vcnt_d, lpf_q;
  logic [3:0]    data_q, data_d;
  logic          line_q, line_d, frame_q, frame_d, df_q, df_d, urun_q, urun_d;
  logic          scan, slot, pulse, last_line, frame_end, geo_ld;

  always_comb begin
    scan      = (state_q == ST_SCAN);
    slot      = scan && (hcnt_q != npl_q);
    pulse     = scan && (hcnt_q == npl_q);
    last_line = (vcnt_q == lpf_q - 1'b1);
    frame_end = pulse && last_line;
    geo_ld    = (state_q == ST_PRIME);
    take      = cfg_en && slot;
    flush     = !cfg_en || state_q == ST_IDLE || state_q == ST_HALT || frame_end;

    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (!cfg_freeze) state_d = ST_PRIME;
      ST_PRIME: if (avail)       state_d = ST_SCAN;
      ST_SCAN:  if (frame_end)   state_d = cfg_freeze ? ST_HALT : ST_PRIME;
      default:  state_d = ST_HALT;
    endcase
    if (!cfg_en) state_d = ST_IDLE;

    hcnt_d = '0;
    vcnt_d = '0;
    if (cfg_en && scan) begin
      hcnt_d = pulse ? '0 : hcnt_q + 1'b1;
      vcnt_d = (pulse && !last_line) ? vcnt_q + 1'b1 : (pulse ? '0 : vcnt_q);
    end

    data_d  = (take && avail) ? (nib ^ {4{cfg_invert}}) : 4'h0;
    line_d  = cfg_en && pulse;
    frame_d = cfg_en && scan && (vcnt_q == '0);
    if (!cfg_en || state_q == ST_IDLE || state_q == ST_HALT) df_d = 1'b0;
    else if (pulse && (cfg_df_line || last_line))            df_d = ~df_q;
    else                                                     df_d = df_q;
    urun_d = cfg_en && (urun_q || (take && !avail));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      vcnt_q  <= '0;
      data_q  <= '0;
      line_q  <= 1'b0;
      frame_q <= 1'b0;
      df_q    <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      vcnt_q  <= vcnt_d;
      data_q  <= data_d;
      line_q  <= line_d;
      frame_q <= frame_d;
      df_q    <= df_d;
      urun_q  <= urun_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npl_q <= '0;
      lpf_q <= '0;
    end else if (geo_ld) begin
      npl_q <= geo_npl;
      lpf_q <= geo_lpf;
    end
  end

  assign lcd_data  = data_q;
  assign lcd_line  = line_q;
  assign lcd_frame = frame_q;
  assign lcd_df    = df_q;
  assign underrun  = urun_q;

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (lcd_data == 4'h0 && !lcd_line && !lcd_frame && !lcd_df)); // R1
  AST_LINE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && npl_q != '0) |=> !line_q); // R2
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_q && cfg_en) |=> urun_q); // R7
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && $past(state_q) == ST_HALT) |->
      (!line_q && !frame_q && data_q == 4'h0)); // R8

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int WW = 10,
  parameter int HW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_freeze,
  input  logic [1:0]    cfg_bpp,
  input  logic          cfg_split,
  input  logic [WW-1:0] cfg_width,
  input  logic [HW-1:0] cfg_height,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic          cfg_invert,
  input  logic          cfg_df_line,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_grant,
  input  logic [DW-1:0] mem_rdata,
  output logic [3:0]    lcd_data,
  output logic          lcd_line,
  output logic          lcd_frame,
  output logic          lcd_df,
  output logic          underrun
);

  logic [WW-1:0] geo_npl;
  logic [HW-1:0] geo_lpf;
  logic          take, flush, avail;
  logic [3:0]    nib;

  lcd_geom #(.WW(WW), .HW(HW)) u_geom (
    .bpp(cfg_bpp), .split(cfg_split), .width(cfg_width), .height(cfg_height),
    .npl(geo_npl), .lpf(geo_lpf)
  );

  lcd_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .flush(flush), .take(take),
    .start_addr(cfg_start), .end_addr(cfg_end),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_grant(mem_grant),
    .mem_rdata(mem_rdata), .avail(avail), .nib(nib)
  );

  lcd_timing #(.WW(WW), .HW(HW)) u_timing (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_freeze(cfg_freeze),
    .cfg_invert(cfg_invert), .cfg_df_line(cfg_df_line),
    .geo_npl(geo_npl), .geo_lpf(geo_lpf), .avail(avail), .nib(nib),
    .take(take), .flush(flush), .lcd_data(lcd_data), .lcd_line(lcd_line),
    .lcd_frame(lcd_frame), .lcd_df(lcd_df), .underrun(underrun)
  );

endmodule

// File: tb/lcd_scan_ctrl_tb.sv
`timescale 1ns/1ps
module lcd_scan_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en, cfg_freeze, cfg_split, cfg_invert, cfg_df_line;
  logic [1:0]  cfg_bpp;
  logic [9:0]  cfg_width;
  logic [8:0]  cfg_height;
  logic [15:0] cfg_start, cfg_end;
  logic        mem_req, mem_grant;
  logic [15:0] mem_addr, mem_rdata;
  logic [3:0]  lcd_data;
  logic        lcd_line, lcd_frame, lcd_df, underrun;

  int checks = 0;
  int errors = 0;
  int viol   = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd40503 + 32'd12345;
    return t[15:0];
  endfunction

  assign mem_rdata = memf(mem_addr);

  lcd_scan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_freeze(cfg_freeze),
    .cfg_bpp(cfg_bpp), .cfg_split(cfg_split), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .cfg_invert(cfg_invert), .cfg_df_line(cfg_df_line),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_grant(mem_grant),
    .mem_rdata(mem_rdata), .lcd_data(lcd_data), .lcd_line(lcd_line),
    .lcd_frame(lcd_frame), .lcd_df(lcd_df), .underrun(underrun)
  );

  always @(negedge clk)
    if (rst_n && mem_req && (mem_addr < cfg_start || mem_addr >= cfg_end)) viol++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] bpp, input logic split, input int w,
                       input int h, input int st, input int en_a,
                       input logic inv, input logic dfl);
    @(negedge clk);
    cfg_en = 1'b0; cfg_freeze = 1'b0;
    repeat (2) @(negedge clk);
    cfg_bpp = bpp; cfg_split = split; cfg_width = 10'(w); cfg_height = 9'(h);
    cfg_start = 16'(st); cfg_end = 16'(en_a); cfg_invert = inv; cfg_df_line = dfl;
    @(negedge clk);
    cfg_en = 1'b1;
  endtask

  task automatic check_frame(input int npl, input int lines, input bit inv,
                             input int avail, input bit frz, input string dreq,
                             output bit df_first);
    int waitc = 0;
    int bad_d = 0, bad_l = 0, bad_f = 0, bad_df = 0;
    int k = 0;
    while (lcd_frame !== 1'b1 && waitc < 3000) begin
      @(negedge clk);
      waitc++;
    end
    chk(waitc < 3000, "R3", "frame strobe appears", waitc, 0);
    if (frz) cfg_freeze = 1'b1;
    df_first = lcd_df;
    for (int v = 0; v < lines; v++) begin
      for (int h = 0; h < npl; h++) begin
        logic [15:0] wd;
        logic [3:0]  e;
        logic        edf;
        wd = memf(cfg_start + 16'(k / 4));
        e  = (k / 4 >= avail) ? 4'h0 : (wd[(k % 4)*4 +: 4] ^ {4{inv}});
        edf = cfg_df_line ? (df_first ^ v[0]) : df_first;
        if (lcd_data !== e) begin
          bad_d++;
          if (bad_d == 1) $display("  first data mismatch line %0d nibble %0d: %h vs %h", v, h, lcd_data, e);
        end
        if (lcd_line !== 1'b0) bad_l++;
        if (lcd_frame !== (v == 0)) bad_f++;
        if (lcd_df !== edf) bad_df++;
        k++;
        @(negedge clk);
      end
      if (lcd_line !== 1'b1 || lcd_data !== 4'h0) bad_l++;
      if (lcd_frame !== (v == 0)) bad_f++;
      @(negedge clk);
    end
    if (lcd_line !== 1'b0) bad_l++;
    if (lcd_frame !== 1'b0) bad_f++;
    chk(bad_d == 0, dreq, "nibble stream mismatches", bad_d, 0);
    chk(bad_l == 0, "R2", "line strobe/length mismatches", bad_l, 0);
    chk(bad_f == 0, "R3", "frame strobe/line count mismatches", bad_f, 0);
    chk(bad_df == 0, "R6", "bias toggle mismatches", bad_df, 0);
  endtask

  task automatic t_reset();
    chk(lcd_data == 4'h0 && !lcd_line && !lcd_frame && !lcd_df, "R1", "outputs idle after reset",
        {lcd_data, lcd_line, lcd_frame, lcd_df}, 0);
    chk(!mem_req && !underrun, "R1", "no request, no underrun after reset", {mem_req, underrun}, 0);
  endtask

  task automatic t_colour();
    bit a, b;
    setup(2'd3, 1'b0, 16, 4, 16'h0100, 16'h0200, 1'b0, 1'b0);
    check_frame(6, 4, 1'b0, 1000, 1'b0, "R4", a);
    check_frame(6, 4, 1'b0, 1000, 1'b0, "R9", b);
    chk(a != b, "R6", "bias flips between frames", int'(b), int'(!a));
    chk(!underrun, "R4", "no underrun with free memory", int'(underrun), 0);
  endtask

  task automatic t_mono();
    bit a;
    setup(2'd0, 1'b0, 16, 3, 16'h0040, 16'h0100, 1'b0, 1'b0);
    check_frame(4, 3, 1'b0, 1000, 1'b0, "R10", a);
  endtask

  task automatic t_split();
    bit a;
    setup(2'd3, 1'b1, 16, 6, 16'h0080, 16'h0100, 1'b0, 1'b0);
    check_frame(4, 3, 1'b0, 1000, 1'b0, "R3", a);
  endtask

  task automatic t_invert_line_bias();
    bit a;
    setup(2'd2, 1'b0, 20, 4, 16'h0200, 16'h0300, 1'b1, 1'b1);
    check_frame(5, 4, 1'b1, 1000, 1'b0, "R5", a);
  endtask

  task automatic t_underrun();
    bit a;
    viol = 0;
    setup(2'd1, 1'b0, 16, 2, 16'h0300, 16'h0301, 1'b0, 1'b0);
    check_frame(4, 2, 1'b0, 1, 1'b0, "R7", a);
    chk(underrun == 1'b1, "R7", "underrun set after missing word", int'(underrun), 1);
    repeat (10) @(negedge clk);
    chk(underrun == 1'b1, "R7", "underrun sticky", int'(underrun), 1);
    chk(viol == 0, "R7", "reads outside start..end", viol, 0);
    cfg_en = 1'b0;
    @(negedge clk);
    chk(underrun == 1'b0, "R7", "underrun cleared by disable", int'(underrun), 0);
  endtask

  task automatic t_disable();
    bit a;
    setup(2'd3, 1'b0, 16, 4, 16'h0100, 16'h0200, 1'b0, 1'b0);
    while (lcd_frame !== 1'b1) @(negedge clk);
    repeat (9) @(negedge clk);
    cfg_en = 1'b0;
    @(negedge clk);
    chk(lcd_data == 4'h0 && !lcd_line && !lcd_frame && !lcd_df && !mem_req, "R1",
        "outputs idle one clock after disable", {mem_req, lcd_data, lcd_line, lcd_frame, lcd_df}, 0);
    @(negedge clk);
    cfg_en = 1'b1;
    check_frame(6, 4, 1'b0, 1000, 1'b0, "R1", a);
  endtask

  task automatic t_freeze();
    bit a;
    int busy = 0;
    setup(2'd3, 1'b0, 16, 4, 16'h0100, 16'h0200, 1'b0, 1'b0);
    check_frame(6, 4, 1'b0, 1000, 1'b1, "R8", a);
    for (int i = 0; i < 100; i++) begin
      if (lcd_frame || lcd_line || lcd_data != 4'h0 || mem_req) busy++;
      @(negedge clk);
    end
    chk(busy == 0, "R8", "silent while frozen", busy, 0);
    cfg_freeze = 1'b0;
    busy = 0;
    for (int i = 0; i < 60; i++) begin
      if (lcd_frame || lcd_line || mem_req) busy++;
      @(negedge clk);
    end
    chk(busy == 0, "R8", "no resume without enable cycle", busy, 0);
    cfg_en = 1'b0;
    @(negedge clk);
    cfg_en = 1'b1;
    check_frame(6, 4, 1'b0, 1000, 1'b0, "R9", a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_freeze = 1'b0; cfg_bpp = 2'd0; cfg_split = 1'b0;
    cfg_width = '0; cfg_height = '0; cfg_start = '0; cfg_end = '0;
    cfg_invert = 1'b0; cfg_df_line = 1'b0; mem_grant = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_colour();
    t_mono();
    t_split();
    t_invert_line_bias();
    t_underrun();
    t_disable();
    t_freeze();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule